// File: doc/BRIEF.md
# Cyclic Transparent Byte Replay Transmitter

This block is the transmit end of a serial line that can replay a short stored message forever. A host loads between one and thirty-two bytes through a write strobe and then writes an 8-bit command. When the command asks for repeated transparent transmission, the stored bytes are sent one after another, least significant bit first. One bit is sent for each clock in which the bit-clock enable is high. After the last loaded byte the stream returns to byte 0 with no gap. No flags, stuffing or checksums are added.

The stored bytes are not consumed, so the same buffer plays until the host cancels it. Cancelling is done in one of two ways. A command write whose repeat bit is clear ends the replay and keeps the buffer. A soft-reset command ends the replay and empties the buffer. Whenever nothing is being replayed, the line carries a steady run of ones. Bytes offered while a replay is running are dropped, and a sticky error output records that this happened.

Top module: `cyc_tx_top`

## Requirements
- R1: After the asynchronous reset, tx_out is 1, busy is 0 and wr_err is 0.
- R2: While busy is 0, each wr_en cycle appends wr_data to the buffer, up to 32 bytes. Writes made when the buffer already holds 32 bytes are dropped and do not set wr_err.
- R3: A command write that has bit 5 (repeat) and bit 2 (transparent) set and bit 0 clear starts replay. This applies only while busy is 0 and the buffer is non-empty. busy is 1 from the next cycle on.
- R4: During replay, tx_out shows stored bits LSB first, bytes in load order, wrapping from the last loaded byte to byte 0 with no gap. The bit changes only on a clock edge at which bit_en is high, and tx_out holds its value otherwise. The first bit appears after the first such edge that follows the start edge.
- R5: During replay, a command write with bit 5 set and bit 0 clear leaves the stream uninterrupted.
- R6: During replay, a command write with bit 5 clear ends it at that edge: busy becomes 0 and tx_out becomes 1. The buffer is kept, so a later start replays it from byte 0. While busy is 0, tx_out stays 1.
- R7: A command write with bit 0 (soft reset) set takes priority over all other bits. It ends any replay, empties the buffer, clears wr_err and drives tx_out to 1.
- R8: A start command issued while the buffer is empty is ignored: busy stays 0 and tx_out stays 1.
- R9: wr_en while busy is 1 does not change the buffer and sets wr_err. wr_err stays 1 until a soft reset.
- R10: While idle, a command write with bit 5 set but bit 2 clear does not start replay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to append |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command: bit 5 repeat, bit 2 transparent, bit 0 soft reset |
| bit_en | input | 1 | Bit-clock enable |
| tx_out | output | 1 | Serial line output |
| busy | output | 1 | Replay running |
| wr_err | output | 1 | Sticky flag: write attempted during replay |

## Verification
On every cycle, the assertions check the following:
- the line is high whenever no replay runs, and it holds when no bit enable arrives;
- the buffer never exceeds its depth;
- start, stop and soft-reset commands take effect at the next edge;
- an empty buffer never starts;
- the error flag is sticky and is set by writes during replay.

Only the bench's scoreboard scenarios can show the content of the stream: LSB-first bit order, the seamless wrap over one, three and thirty-two bytes under sparse bit enables, that a keep-going command leaves the stream intact, and that a refused write leaves the replayed data unchanged.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int CMD_W    = 8;
  localparam int CMD_RPT  = 5;
  localparam int CMD_TRN  = 2;
  localparam int CMD_SRST = 0;

  typedef struct packed {
    logic start;
    logic halt;
    logic clr;
  } ctx_ctl_t;
endpackage

// File: rtl/ctx_fifo.sv
module ctx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             lock,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_byte,
  output logic [LVL_W-1:0] level,
  output logic             wr_reject
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [LVL_W-1:0] level_q, level_d;
  logic             do_wr;

  // the write pointer doubles as the fill level: nothing is ever consumed
  always_comb begin
    do_wr   = wr_req && !lock && !clr && (level_q < LVL_W'(DEPTH));
    level_d = level_q;
    if (clr)        level_d = '0;
    else if (do_wr) level_d = level_q + LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[level_q[IDX_W-1:0]] <= wr_data;
  end

  assign rd_byte   = mem[rd_idx];
  assign level     = level_q;
  assign wr_reject = wr_req && lock && !clr;
endmodule

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             cmd_rpt,
  input  logic             cmd_trn,
  input  logic             cmd_srst,
  input  logic             buf_nz,
  input  logic             wr_reject,
  output logic             active,
  output ctx_ctl_t         ctl,
  output logic             err
);
  logic active_q, active_d;
  logic err_q, err_d;
  logic srst;

  always_comb begin
    srst      = cmd_we && cmd_srst;
    ctl.clr   = srst;
    ctl.start = cmd_we && !srst && !active_q && cmd_rpt && cmd_trn && buf_nz;
    ctl.halt  = active_q && (srst || (cmd_we && !cmd_rpt));

    active_d = active_q;
    if (srst || ctl.halt) active_d = 1'b0;
    else if (ctl.start)   active_d = 1'b1;

    err_d = err_q;
    if (srst)           err_d = 1'b0;
    else if (wr_reject) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      err_q    <= err_d;
    end
  end

  assign active = active_q;
  assign err    = err_q;
endmodule

// File: rtl/ctx_ser.sv
module ctx_ser #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BIT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             halt,
  input  logic             bit_en,
  input  logic [LVL_W-1:0] level,
  input  logic [WIDTH-1:0] rd_byte,
  output logic [IDX_W-1:0] rd_idx,
  output logic             tx_out
);
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [IDX_W-1:0] byte_q, byte_d;
  logic             tx_q, tx_d;
  logic             last_bit, last_byte;

  always_comb begin
    last_bit  = (bit_q == BIT_W'(WIDTH - 1));
    last_byte = (LVL_W'(byte_q) == level - LVL_W'(1));
    bit_d  = bit_q;
    byte_d = byte_q;
    tx_d   = tx_q;
    if (start) begin
      bit_d  = '0;
      byte_d = '0;
    end
    if (!run || halt) begin
      tx_d = 1'b1;
    end else if (bit_en) begin
      tx_d = rd_byte[bit_q];
      if (last_bit) begin
        bit_d  = '0;
        byte_d = last_byte ? '0 : byte_q + IDX_W'(1);
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      byte_q <= '0;
      tx_q   <= 1'b1;
    end else begin
      bit_q  <= bit_d;
      byte_q <= byte_d;
      tx_q   <= tx_d;
    end
  end

  assign rd_idx = byte_q;
  assign tx_out = tx_q;
endmodule

// File: rtl/cyc_tx_top.sv
module cyc_tx_top
  import ctx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             bit_en,
  output logic             tx_out,
  output logic             busy,
  output logic             wr_err
);
  ctx_ctl_t         ctl;
  logic             active;
  logic             wr_reject;
  logic [LVL_W-1:0] level;
  logic [IDX_W-1:0] rd_idx;
  logic [WIDTH-1:0] rd_byte;
  logic             unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd_data[7:6], cmd_data[4:3], cmd_data[1]};

  ctx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(ctl.clr), .lock(active),
    .wr_req(wr_en), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_byte(rd_byte), .level(level), .wr_reject(wr_reject)
  );

  ctx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we),
    .cmd_rpt(cmd_data[CMD_RPT]), .cmd_trn(cmd_data[CMD_TRN]),
    .cmd_srst(cmd_data[CMD_SRST]), .buf_nz(level != '0),
    .wr_reject(wr_reject), .active(active), .ctl(ctl), .err(wr_err)
  );

  ctx_ser #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ser (
    .clk(clk), .rst_n(rst_n), .run(active), .start(ctl.start),
    .halt(ctl.halt), .bit_en(bit_en), .level(level),
    .rd_byte(rd_byte), .rd_idx(rd_idx), .tx_out(tx_out)
  );

  assign busy = active;
endmodule

// File: rtl/ctx_chk.sv
module ctx_chk #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             cmd_we,
  input logic [7:0]       cmd_data,
  input logic             bit_en,
  input logic             tx_out,
  input logic             busy,
  input logic             wr_err,
  input logic [LVL_W-1:0] level
);
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out);

  a_r4_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(bit_en) && !$past(cmd_we)) |-> $stable(tx_out));

  a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r2_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level) == LVL_W'(DEPTH) && !$past(cmd_we && cmd_data[0]))
      |-> level == LVL_W'(DEPTH));

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_we && cmd_data[5] && cmd_data[2] && !cmd_data[0])
      && $past(level) != '0) |-> busy);

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_we && !cmd_data[5]) |-> (!busy && tx_out));

  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_we && cmd_data[0]) |-> (level == '0 && !busy && !wr_err && tx_out));

  a_r8_empty_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level) == '0 && !$past(busy)) |-> !busy);

  a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy && wr_en) && !$past(cmd_we && cmd_data[0])) |-> wr_err);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_err) && !$past(cmd_we && cmd_data[0])) |-> wr_err);

  a_r9_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(cmd_we && cmd_data[0])) |-> $stable(level));
endmodule

bind cyc_tx_top ctx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_we(cmd_we),
  .cmd_data(cmd_data), .bit_en(bit_en), .tx_out(tx_out), .busy(busy),
  .wr_err(wr_err), .level(level)
);

// File: tb/test_cyc_tx_top.sv
`timescale 1ns/100ps
module test_cyc_tx_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       bit_en;
  logic       tx_out, busy, wr_err;

  int   n_chk = 0, n_fail = 0;
  bit   exp_q[$];
  logic [7:0] ref_mem [32];
  int   ref_n = 0;
  int   be_mode = 0;
  int   be_cnt = 0;
  logic be_s, busy_s;
  logic [7:0] lfsr = 8'h5b;

  always #2.5 clk = ~clk;

  cyc_tx_top i_cyc_tx_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_we(cmd_we), .cmd_data(cmd_data), .bit_en(bit_en),
    .tx_out(tx_out), .busy(busy), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bit enable: dense or pseudo-random sparse
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    be_cnt <= be_cnt + 1;
    if (be_mode == 0) bit_en <= 1'b1;
    else              bit_en <= lfsr[0] | (be_cnt % 3 == 0);
  end

  // monitor: pops expected bits when a bit is due
  always @(posedge clk) begin
    be_s   = bit_en;
    busy_s = busy;
    #1;
    if (be_s && busy_s && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(tx_out === e, "R4 stream bit", tx_out, e);
    end
  end

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    if (!busy && ref_n < 32) begin
      ref_mem[ref_n] = d;
      ref_n++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] v);
    @(negedge clk);
    cmd_we = 1'b1; cmd_data = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic push_loops(input int loops);
    for (int l = 0; l < loops; l++)
      for (int i = 0; i < ref_n; i++)
        for (int b = 0; b < 8; b++)
          exp_q.push_back(ref_mem[i][b]);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic idle_check(input string req, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(busy === 1'b0 && tx_out === 1'b1, req, {busy, tx_out}, 2'b01);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx_out === 1'b1 && busy === 1'b0 && wr_err === 1'b0, "R1 reset state",
        {tx_out, busy, wr_err}, 3'b100);
    rst_n = 1'b1;
    idle_check("R1 idle after reset", 3);

    // R2/R3: load three bytes, start, R5 keep-going and R9 refused write mid-stream
    wr_byte(8'hA5); wr_byte(8'h3C); wr_byte(8'h01);
    push_loops(3);
    cmd(8'h24);
    chk(busy === 1'b1, "R3 busy after start", busy, 1);
    repeat (10) @(negedge clk);
    cmd(8'h20);
    chk(busy === 1'b1, "R5 still busy after keep-going", busy, 1);
    wr_byte(8'h77);
    chk(wr_err === 1'b1, "R9 error set by write during replay", wr_err, 1);
    drain();
    cmd(8'h04);
    chk(busy === 1'b0 && tx_out === 1'b1, "R6 stop on repeat bit clear",
        {busy, tx_out}, 2'b01);
    idle_check("R6 idle ones after stop", 6);
    chk(wr_err === 1'b1, "R9 error sticky", wr_err, 1);

    // R6 buffer kept, R9 refused byte absent: replay again from byte 0
    push_loops(2);
    cmd(8'h24);
    drain();
    cmd(8'h00);
    idle_check("R6 idle after second stop", 3);

    // R10: repeat without transparent does not start
    cmd(8'h20);
    idle_check("R10 no start without transparent bit", 5);

    // R7 soft reset while idle, then R8 start on empty buffer
    cmd(8'h01);
    chk(wr_err === 1'b0, "R7 soft reset clears error", wr_err, 0);
    ref_n = 0;
    cmd(8'h24);
    idle_check("R8 empty start ignored", 6);

    // single byte replay, then soft reset during replay
    wr_byte(8'h80);
    push_loops(4);
    cmd(8'h24);
    drain();
    cmd(8'h25);
    chk(busy === 1'b0 && tx_out === 1'b1, "R7 soft reset ends replay",
        {busy, tx_out}, 2'b01);
    ref_n = 0;
    cmd(8'h24);
    idle_check("R7 buffer emptied by soft reset", 4);

    // R2: fill to 32, 33rd dropped without error; sparse bit enables
    for (int i = 0; i < 33; i++) wr_byte(8'(i * 37 + 5));
    chk(wr_err === 1'b0, "R2 overflow write sets no error", wr_err, 0);
    chk(ref_n == 32, "R2 reference depth", ref_n, 32);
    be_mode = 1;
    push_loops(2);
    cmd(8'h24);
    drain();
    cmd(8'h04);
    idle_check("R6 idle after full replay", 4);
    chk(exp_q.size() == 0, "R4 all expected bits observed", exp_q.size(), 0);

    finish_run();
  end
endmodule